// File: doc/BRIEF.md
# Mains Period Tracker with Integration-Time Correction

This block times the period of a conditioned mains square wave against the fixed local clock and turns the result into a small signed correction word. The integrating converter's sequencer uses that word to lengthen or shorten its integration time so that the integration time matches a whole mains period. The local clock is never retuned. The only thing that changes is how many clock ticks the converter integrates for. The period is timed reciprocally, by counting clock ticks between rising mains edges. Every accepted period enters a boxcar of the last 2^AVG_LOG2 periods. This averaging smooths the jitter and distortion of the mains signal.

Each rising edge passes through a synchroniser. An edge that comes too soon after the last one is treated as a glitch and ignored. A period that is too long is dropped, and timing restarts from that edge. The window of accepted periods lies within TOL_PERMIL per mille of nominal. A select input chooses the 50 Hz or 60 Hz nominal period. The correction is the floored window average minus the nominal period, in clock ticks, saturated to CORR_W bits.

The converter reads the correction through a read-only SPI slave using mode 0. The slave captures the word when chip select falls. A reading therefore never mixes two updates, and the converter can apply it between conversions.

Top module: `mains_period_tracker`

## Requirements
- R1: After reset, and until 2^AVG_LOG2 periods have been accepted, the correction word reads 0.
- R2: A period is the number of clock cycles between two successive accepted rising edges of `mains_in`. It enters the average only if it lies in [nom - nom*TOL_PERMIL/1000, nom + nom*TOL_PERMIL/1000], both bounds inclusive.
- R3: The correction is floor(sum of the last 2^AVG_LOG2 accepted periods / 2^AVG_LOG2) minus the nominal period, in two's complement.
- R4: The correction saturates to the range [-2^(CORR_W-1), 2^(CORR_W-1)-1].
- R5: A rising edge that comes fewer than the lower-bound ticks after the reference edge is ignored. It does not restart the period timing.
- R6: A period longer than the upper bound is dropped from the average, and its closing edge becomes the new reference.
- R7: With `sel_60`=0 the nominal period is NOM50_TICKS, and with `sel_60`=1 it is NOM60_TICKS. Any change of `sel_60` empties the average, so the correction reads 0 again.
- R8: The SPI slave works in mode 0 and shifts out CORR_W bits MSB first. It loads the word on the falling edge of `spi_cs_n` and holds that value for the whole transaction. `spi_miso` is 0 while `spi_cs_n` is high.
- R9: The first rising edge after reset or after a mode change only sets the reference. It closes no period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed local clock |
| rst_n | input | 1 | Active-low reset |
| mains_in | input | 1 | Conditioned mains square wave (asynchronous) |
| sel_60 | input | 1 | Nominal select: 0 = 50 Hz period, 1 = 60 Hz period |
| spi_sclk | input | 1 | SPI clock from the converter (asynchronous, slow against clk) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI data out, correction word MSB first |

## Verification
Assertions check four things on every cycle. Every period handed to the average lies inside the current acceptance window. A glitch edge leaves the period count running. The correction stays 0 while the window is not yet full and right after a mode change. The SPI output is quiet with chip select high, and the loaded word does not move between clock edges. Some behaviour only the bench scenarios can show. These are the arithmetic of the floored average, the inclusive window bounds, saturation at both ends, dropping a long period, and the first edge after a mode switch acting only as a reference. The bench also reads the word across a window update, which shows that the word loaded at chip select is the word delivered.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
   // Acceptance limits for one nominal period, in clock ticks
   function automatic longint lower_ticks(input longint nom, input longint tol_permil);
      return nom - (nom * tol_permil) / 1000;
   endfunction

   function automatic longint upper_ticks(input longint nom, input longint tol_permil);
      return nom + (nom * tol_permil) / 1000;
   endfunction
endpackage

// File: rtl/mpt_sync.sv
module mpt_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prv
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpt_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh[0] <= RST_VAL;
      else        sh[0] <= din;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) sh[i] <= RST_VAL;
         else        sh[i] <= sh[i-1];
      end
   end

   assign lvl = sh[STAGES-1];
   assign prv = sh[STAGES];
endmodule

// File: rtl/mpt_period_meter.sv
module mpt_period_meter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             edge_p,
   input  logic [CNT_W-1:0] lo,
   input  logic [CNT_W-1:0] hi,
   output logic             per_valid,
   output logic [CNT_W-1:0] per_ticks
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt;
   logic             have_ref;
   logic             early;

   assign early = cnt < lo;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt       <= '0;
         have_ref  <= 1'b0;
         per_valid <= 1'b0;
         per_ticks <= '0;
      end else begin
         per_valid <= 1'b0;
         if (edge_p && !have_ref) begin
            have_ref <= 1'b1;
            cnt      <= CNT_W'(1);
         end else if (edge_p && !early) begin
            per_valid <= (cnt <= hi);
            per_ticks <= cnt;
            cnt       <= CNT_W'(1);
         end else if (have_ref && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_PERIOD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      per_valid |-> (per_ticks >= lo && per_ticks <= hi)); // R2

   AST_GLITCH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_p && have_ref && early && !clr) |=> (cnt == $past(cnt) + 1'b1)); // R5

   AST_NO_PERIOD_WITHOUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_p && !have_ref) |=> !per_valid); // R9
endmodule

// File: rtl/mpt_window_avg.sv
module mpt_window_avg #(
   parameter int CNT_W    = 24,
   parameter int AVG_LOG2 = 3,
   parameter int CORR_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     per_valid,
   input  logic [CNT_W-1:0]         per_ticks,
   input  logic [CNT_W-1:0]         nom,
   output logic signed [CORR_W-1:0] corr
);
   localparam int N     = 1 << AVG_LOG2;
   localparam int SUM_W = CNT_W + AVG_LOG2;
   localparam int DW    = (CNT_W >= CORR_W) ? CNT_W + 1 : CORR_W + 1;
   localparam logic signed [DW-1:0] SAT_HI = DW'((longint'(1) <<< (CORR_W - 1)) - 1);
   localparam logic signed [DW-1:0] SAT_LO = -SAT_HI - DW'(1);

   if (AVG_LOG2 < 1 || AVG_LOG2 > 6) begin : g_bad_depth
      $error("mpt_window_avg: AVG_LOG2 out of range");
   end

   logic [CNT_W-1:0]  win [N];
   logic [AVG_LOG2:0] fill;
   logic [SUM_W-1:0]  sum;
   logic              full;
   logic [CNT_W-1:0]  avg;
   logic signed [DW-1:0] diff;
   logic signed [DW-1:0] clamped;

   assign full = fill[AVG_LOG2];

   always_ff @(posedge clk) begin
      if (per_valid) win[0] <= per_ticks;
   end

   for (genvar i = 1; i < N; i++) begin : g_tap
      always_ff @(posedge clk) begin
         if (per_valid) win[i] <= win[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fill <= '0;
         sum  <= '0;
      end else if (per_valid) begin
         sum <= sum + SUM_W'(per_ticks) - (full ? SUM_W'(win[N-1]) : '0);
         if (!full) fill <= fill + 1'b1;
      end
   end

   assign avg  = sum[SUM_W-1:AVG_LOG2];
   assign diff = $signed(DW'(avg)) - $signed(DW'(nom));

   always_comb begin
      if (diff > SAT_HI)      clamped = SAT_HI;
      else if (diff < SAT_LO) clamped = SAT_LO;
      else                    clamped = diff;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) corr <= '0;
      else if (full)     corr <= clamped[CORR_W-1:0];
      else               corr <= '0;
   end

   AST_ZERO_UNTIL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !full |=> (corr == '0)); // R1

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AVG_LOG2+1)'(N)); // R3

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fill == '0 && corr == '0)); // R7
endmodule

// File: rtl/mpt_spi_tx.sv
module mpt_spi_tx #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk,
   input  logic         cs_n,
   input  logic [W-1:0] word,
   output logic         miso
);
   if (W < 2) begin : g_bad_w
      $error("mpt_spi_tx: W must be at least 2");
   end

   logic cs_lvl, cs_prv, sck_lvl, sck_prv;
   logic cs_fall, cs_rise, sck_fall;
   logic act;
   logic [W-1:0] shreg;

   mpt_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .lvl(cs_lvl), .prv(cs_prv));

   mpt_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk), .lvl(sck_lvl), .prv(sck_prv));

   assign cs_fall  = !cs_lvl && cs_prv;
   assign cs_rise  = cs_lvl && !cs_prv;
   assign sck_fall = !sck_lvl && sck_prv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act   <= 1'b0;
         shreg <= '0;
      end else if (cs_fall) begin
         act   <= 1'b1;
         shreg <= word;
      end else if (cs_rise) begin
         act   <= 1'b0;
      end else if (act && sck_fall) begin
         shreg <= {shreg[W-2:0], 1'b0};
      end
   end

   assign miso = act ? shreg[W-1] : 1'b0;

   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_lvl) && cs_lvl) |-> !miso); // R8

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !sck_fall && !cs_fall) |=> $stable(shreg)); // R8
endmodule

// File: rtl/mains_period_tracker.sv
module mains_period_tracker #(
   parameter int NOM50_TICKS = 2_500_000,
   parameter int NOM60_TICKS = 2_083_333,
   parameter int TOL_PERMIL  = 20,
   parameter int AVG_LOG2    = 3,
   parameter int CORR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mains_in,
   input  logic sel_60,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   output logic spi_miso
);
   import mpt_pkg::*;

   localparam longint LO50   = lower_ticks(NOM50_TICKS, TOL_PERMIL);
   localparam longint HI50   = upper_ticks(NOM50_TICKS, TOL_PERMIL);
   localparam longint LO60   = lower_ticks(NOM60_TICKS, TOL_PERMIL);
   localparam longint HI60   = upper_ticks(NOM60_TICKS, TOL_PERMIL);
   localparam longint HI_MAX = (HI50 > HI60) ? HI50 : HI60;
   localparam int     CNT_W  = $clog2(HI_MAX + 2) + 1;

   if (CORR_W != 8 && CORR_W != 16) begin : g_bad_corr_w
      $error("mains_period_tracker: CORR_W must be 8 or 16");
   end
   if (TOL_PERMIL < 1 || TOL_PERMIL > 400) begin : g_bad_tol
      $error("mains_period_tracker: TOL_PERMIL out of range");
   end
   if (NOM60_TICKS >= NOM50_TICKS || NOM60_TICKS < 16) begin : g_bad_nom
      $error("mains_period_tracker: nominal periods inconsistent");
   end

   logic             mode_q;
   logic             clr;
   logic             m_lvl, m_prv, m_edge;
   logic [CNT_W-1:0] nom, lo, hi;
   logic             per_valid;
   logic [CNT_W-1:0] per_ticks;
   logic signed [CORR_W-1:0] corr;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= sel_60;
   end

   assign clr = (sel_60 != mode_q);
   assign nom = mode_q ? CNT_W'(NOM60_TICKS) : CNT_W'(NOM50_TICKS);
   assign lo  = mode_q ? CNT_W'(LO60) : CNT_W'(LO50);
   assign hi  = mode_q ? CNT_W'(HI60) : CNT_W'(HI50);

   mpt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mains_sync (
      .clk(clk), .rst_n(rst_n), .din(mains_in), .lvl(m_lvl), .prv(m_prv));

   assign m_edge = m_lvl && !m_prv;

   mpt_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .edge_p(m_edge),
      .lo(lo), .hi(hi), .per_valid(per_valid), .per_ticks(per_ticks));

   mpt_window_avg #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .CORR_W(CORR_W)) u_avg (
      .clk(clk), .rst_n(rst_n), .clr(clr), .per_valid(per_valid),
      .per_ticks(per_ticks), .nom(nom), .corr(corr));

   mpt_spi_tx #(.W(CORR_W), .STAGES(SYNC_STAGES)) u_spi (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
      .word(corr), .miso(spi_miso));

   AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mode_q == $past(sel_60))); // R7
endmodule

// File: tb/mains_period_tracker_test.sv
`timescale 1ns/1ps
module mains_period_tracker_test;
   localparam int NOM50 = 1200;
   localparam int NOM60 = 1000;
   localparam int TOL   = 150;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mains = 1'b0;
   logic sel_60 = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic miso;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int pat [4] = '{1200, 1200, 1200, 1200};
   int edge_no = 0;
   bit glitch = 1'b0;
   bit stretch = 1'b0;
   bit gen_on = 1'b0;

   always #4 clk = ~clk;

   mains_period_tracker #(
      .NOM50_TICKS(NOM50), .NOM60_TICKS(NOM60), .TOL_PERMIL(TOL),
      .AVG_LOG2(2), .CORR_W(8), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mains_in(mains), .sel_60(sel_60),
      .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_miso(miso));

   function automatic int exp_corr(input int p0, input int p1, input int p2,
                                   input int p3, input int nom);
      int d;
      d = (p0 + p1 + p2 + p3) / 4 - nom;
      if (d > 127)  d = 127;
      if (d < -128) d = -128;
      return d;
   endfunction

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s got=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic spi_read(input int half, output int val);
      logic [7:0] w;
      @(negedge clk) cs_n = 1'b0;
      repeat (half) @(negedge clk);
      for (int b = 7; b >= 0; b--) begin
         sclk = 1'b1;
         w[b] = miso;
         repeat (half) @(negedge clk);
         sclk = 1'b0;
         repeat (half) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (half) @(negedge clk);
      val = int'($signed(w));
   endtask

   task automatic wait_edges(input int n);
      int e0;
      e0 = edge_no;
      wait (edge_no >= e0 + n);
      repeat (50) @(negedge clk);
   endtask

   task automatic set_all(input int p);
      for (int i = 0; i < 4; i++) pat[i] = p;
   endtask

   // mains generator: rising edges spaced by pat[] in clock cycles
   initial begin
      int idx;
      int cur;
      int h;
      idx = 0;
      wait (gen_on);
      forever begin
         if (stretch) begin
            cur = 1500;
            stretch = 1'b0;
         end else begin
            cur = pat[idx];
            idx = (idx + 1) % 4;
         end
         h = cur / 2;
         @(negedge clk) mains = 1'b1;
         edge_no++;
         repeat (h - 1) @(negedge clk);
         mains = 1'b0;
         if (glitch) begin
            glitch = 1'b0;
            repeat (10) @(negedge clk);
            mains = 1'b1;
            repeat (3) @(negedge clk);
            mains = 1'b0;
            repeat (cur - h - 13) @(negedge clk);
         end else begin
            repeat (cur - h) @(negedge clk);
         end
      end
   end

   initial begin
      repeat (195_000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog got=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int v;
      int r [4];
      void'($urandom(32'd20190807));
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // reset state
      check("R8 miso idle", int'(miso), 0);
      spi_read(20, v);
      check("R1 reset word", v, 0);

      gen_on = 1'b1;
      wait_edges(3);
      spi_read(20, v);
      check("R1 window not full", v, 0);
      wait_edges(5);
      spi_read(20, v);
      check("R3 nominal average", v, 0);

      // random patterns inside the window
      for (int k = 0; k < 2; k++) begin
         for (int i = 0; i < 4; i++) begin
            r[i] = 1100 + int'($urandom % 201);
            pat[i] = r[i];
         end
         wait_edges(5);
         spi_read(20, v);
         check("R3 random pattern", v, exp_corr(r[0], r[1], r[2], r[3], NOM50));
      end

      // floor of the average, positive and negative
      pat = '{1201, 1202, 1202, 1202};
      wait_edges(5);
      spi_read(20, v);
      check("R3 floor positive", v, 1);
      pat = '{1199, 1199, 1199, 1200};
      wait_edges(5);
      spi_read(20, v);
      check("R3 floor negative", v, -1);

      // inclusive bounds of the acceptance window
      pat = '{1380, 1200, 1200, 1200};
      wait_edges(5);
      spi_read(20, v);
      check("R2 upper bound kept", v, 45);
      pat = '{1020, 1200, 1200, 1200};
      wait_edges(5);
      spi_read(20, v);
      check("R2 lower bound kept", v, -45);
      pat = '{1381, 1200, 1200, 1200};
      wait_edges(8);
      spi_read(20, v);
      check("R6 just above bound dropped", v, 0);

      // saturation
      set_all(1330);
      wait_edges(5);
      spi_read(20, v);
      check("R4 positive clamp", v, 127);
      set_all(1060);
      wait_edges(5);
      spi_read(20, v);
      check("R4 negative clamp", v, -128);

      // glitch edge inside the lockout
      set_all(1210);
      wait_edges(5);
      glitch = 1'b1;
      wait_edges(2);
      spi_read(20, v);
      check("R5 glitch ignored", v, 10);

      // over-long period dropped and timing restarted
      set_all(1220);
      wait_edges(5);
      stretch = 1'b1;
      wait_edges(3);
      spi_read(20, v);
      check("R6 long period dropped", v, 20);

      // word captured at chip select across an update
      set_all(1200);
      wait_edges(5);
      spi_read(20, v);
      check("R3 settled before capture test", v, 0);
      begin
         int e0;
         e0 = edge_no;
         wait (edge_no == e0 + 1);
         set_all(1250);
         wait (edge_no == e0 + 2);
         repeat (700) @(negedge clk);
         spi_read(60, v);
         check("R8 word held during transfer", v, 0);
      end
      wait_edges(1);
      spi_read(20, v);
      check("R3 after capture test", v, 25);

      // switch to 60 Hz nominal
      set_all(1005);
      sel_60 = 1'b1;
      repeat (5) @(negedge clk);
      spi_read(20, v);
      check("R7 mode change clears", v, 0);
      wait_edges(4);
      spi_read(20, v);
      check("R9 first edge is reference only", v, 0);
      wait_edges(1);
      spi_read(20, v);
      check("R7 60 Hz nominal", v, 5);
      set_all(860);
      wait_edges(5);
      spi_read(20, v);
      check("R4 negative clamp 60 Hz", v, -128);
      check("R8 miso idle after reads", int'(miso), 0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule